// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Thresholds

This block moves words from a producer clock domain to a consumer clock domain through a dual-port store. Each side keeps its own binary pointer and publishes a gray-coded copy, which the other side samples through a two-stage synchronizer. From its own pointer and the synchronized remote pointer, each side computes the fill level it can see. It derives its status flags from that level, and all flags are active low.

The write side drives a full flag and an almost-full flag. The read side drives an empty flag and an almost-empty flag. A flag asserts on the same edge as the local action that causes it. A flag releases only after the remote pointer has passed the synchronizer, which is on the second rising edge of the flag's own clock after the remote action.

The almost-empty margin and the almost-full margin sit in two offset registers. Reset loads them with parameter defaults. Software-side logic can rewrite them through a small load strobe on the write clock. The offsets are assumed to change only while the queue is idle.

Reads are registered. A word that has been captured into the output register no longer counts toward the fill level.

Top module: `thresh_afifo`

## Requirements
- R1: While `rst_n` is low, both domains go to their reset state on their clock edges. After release, `full_n`=1, `afull_n`=1, `empty_n`=0, `aempty_n`=0 and `rd_data`=0. The almost-empty offset is reloaded to `X_DEF` and the almost-full offset to `Y_DEF`.
- R2: Words leave the read port in the order they were written. `rd_data` takes the next word on a `rclk` edge where `rd_en`=1 and `empty_n`=1. At all other times it holds its value.
- R3: `full_n` goes low right after the `wclk` edge that stores word number DEPTH. A write while `full_n`=0 is dropped, stores nothing and leaves the queue content unchanged.
- R4: After a read from a full queue, `full_n` stays low after the first `wclk` rising edge following that read. It goes high on the second such edge.
- R5: `aempty_n` is low while the read-side level is X or fewer, and high when the level is X+1 or more. After the write that brings the level to X+1, `aempty_n` stays low after the first `rclk` rising edge and goes high on the second.
- R6: A read that lowers the level to X drives `aempty_n` low right after that `rclk` edge. The word then held in `rd_data` is not counted.
- R7: `afull_n` is low when the write-side level is at least DEPTH−Y, and high when it is at most DEPTH−Y−1. It falls right after the write edge that reaches DEPTH−Y. After a read down to DEPTH−Y−1, it rises on the second `wclk` rising edge and not on the first.
- R8: On a `wclk` edge with `cfg_we`=1, `cfg_data` is loaded into the almost-empty offset X when `cfg_sel`=0, or into the almost-full offset Y when `cfg_sel`=1. The R5 and R7 thresholds then use the new values.
- R9: A read while `empty_n`=0 is ignored. `rd_data` keeps its value, `empty_n` stays low, and the next word written is the next word read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in each domain |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store |
| cfg_we | input | 1 | Offset load strobe (write clock) |
| cfg_sel | input | 1 | Offset select: 0 = almost-empty X, 1 = almost-full Y |
| cfg_data | input | $clog2(DEPTH)+1 | Offset value to load |
| full_n | output | 1 | Low when the queue is full (write clock) |
| afull_n | output | 1 | Low when the level is at least DEPTH−Y (write clock) |
| rd_en | input | 1 | Read request |
| rd_data | output | WIDTH | Output register holding the last word read |
| empty_n | output | 1 | Low when no word is available (read clock) |
| aempty_n | output | 1 | Low when the level is X or less (read clock) |

## Verification
The bench counts clock edges after each remote action. It checks that `full_n`, `afull_n` and `aempty_n` are still asserted after the first local edge and released after the second. A design that forgot the synchronizer would release one edge early. A design with an extra stage would release one edge late. The bench also checks that the local action asserts a flag at once, so a design that delayed assertion would let a write overrun a full queue or a read be reported late. Dropped writes while full and ignored reads while empty are checked through the data order that follows them; a pointer that moved anyway would shift or corrupt the sequence. The offset registers are exercised by loading new values and by checking that reset restores the defaults, which exposes an offset that is misrouted or kept across reset.

// File: rtl/thresh_afifo_pkg.sv
`timescale 1ns/100ps
// Shared definitions for the threshold FIFO.
// Assumes nothing beyond IEEE 1800-2017 packages.
package thresh_afifo_pkg;

    // Selects which offset register a configuration load targets.
    typedef enum logic {
        OFS_EMPTY_MARGIN = 1'b0,
        OFS_FULL_MARGIN  = 1'b1
    } ofs_sel_e;

endpackage

// File: rtl/tafifo_mem.sv
`timescale 1ns/100ps
// Dual-port storage array: one synchronous write port, one combinational read port.
// Assumes the caller never writes and reads the same slot in a way that depends on ordering.
module tafifo_mem #(
    parameter int WIDTH = 36,
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             wclk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] store [DEPTH];

    // Store one word per accepted write.
    always_ff @(posedge wclk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    // Present the slot at the read address.
    assign rdata = store[raddr];

endmodule

// File: rtl/tafifo_sync.sv
`timescale 1ns/100ps
// Multi-stage flop chain that moves a gray-coded pointer into another clock domain.
// Assumes the input changes by at most one bit per source clock.
module tafifo_sync #(
    parameter int W      = 10,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    // First stage captures the foreign value.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        // Each further stage settles the previous one.
        always_ff @(posedge clk) begin
            if (!rst_n) stg[g] <= '0;
            else        stg[g] <= stg[g-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/tafifo_wside.sv
`timescale 1ns/100ps
// Write-domain control: write pointer, full and almost-full flags, offset registers.
// Assumes rgray_s is the read pointer after synchronization into wclk.
// Assumes offsets are rewritten only while the queue is idle.
module tafifo_wside
    import thresh_afifo_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int X_DEF = 8,
    parameter int Y_DEF = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          cfg_we,
    input  ofs_sel_e      cfg_sel,
    input  logic [PW-1:0] cfg_data,
    input  logic [PW-1:0] rgray_s,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray,
    output logic          mem_we,
    output logic          full_n,
    output logic          afull_n,
    output logic [PW-1:0] x_off
);

    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    logic [PW-1:0] wbin, wbin_inc, rbin_s, wcount, y_off;
    logic          full;

    // Convert the synchronized gray read pointer back to binary.
    always_comb begin
        for (int i = 0; i < PW; i++) begin
            rbin_s[i] = ^(rgray_s >> i);
        end
    end

    // Fill level as seen from the write side; flags follow from it.
    always_comb begin
        wcount   = wbin - rbin_s;
        full     = (wcount == DEPTH_P);
        full_n   = !full;
        afull_n  = !(wcount >= (DEPTH_P - y_off));
        mem_we   = wr_en && !full;
        wbin_inc = wbin + PW'(1);
    end

    // Advance the write pointer and its gray copy on each accepted write.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (mem_we) begin
            wbin  <= wbin_inc;
            wgray <= wbin_inc ^ (wbin_inc >> 1);
        end
    end

    // Hold the two threshold offsets; reset reloads the defaults.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            x_off <= PW'(X_DEF);
            y_off <= PW'(Y_DEF);
        end else if (cfg_we) begin
            case (cfg_sel)
                OFS_EMPTY_MARGIN: x_off <= cfg_data;
                OFS_FULL_MARGIN:  y_off <= cfg_data;
                default:          x_off <= x_off;
            endcase
        end
    end

    assign waddr = wbin[AW-1:0];

    AST_WRITE_DROPPED_WHEN_FULL: assert property (@(posedge wclk) disable iff (!rst_n)
        (wr_en && !full_n) |=> $stable(wgray)); // R3
    AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!rst_n)
        wcount <= DEPTH_P); // R3
    AST_FULL_IMPLIES_AFULL: assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n |-> !afull_n); // R7
    AST_OFFSETS_RELOADED: assert property (@(posedge wclk) disable iff (!rst_n)
        $past(!rst_n) |-> (x_off == PW'(X_DEF) && y_off == PW'(Y_DEF))); // R1

endmodule

// File: rtl/tafifo_rside.sv
`timescale 1ns/100ps
// Read-domain control: read pointer, output register, empty and almost-empty flags.
// Assumes wgray_s is the write pointer after synchronization into rclk.
// Assumes x_off is static while words are in flight.
module tafifo_rside #(
    parameter int WIDTH = 36,
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic             rclk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [PW-1:0]    x_off,
    input  logic [PW-1:0]    wgray_s,
    input  logic [WIDTH-1:0] mem_rdata,
    output logic [AW-1:0]    raddr,
    output logic [PW-1:0]    rgray,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty_n,
    output logic             aempty_n
);

    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    logic [PW-1:0] rbin, rbin_inc, wbin_s, rcount;
    logic          take;

    // Convert the synchronized gray write pointer back to binary.
    always_comb begin
        for (int i = 0; i < PW; i++) begin
            wbin_s[i] = ^(wgray_s >> i);
        end
    end

    // Fill level as seen from the read side; the output register is not counted.
    always_comb begin
        rcount   = wbin_s - rbin;
        empty_n  = (rcount != '0);
        aempty_n = (rcount > x_off);
        take     = rd_en && empty_n;
        rbin_inc = rbin + PW'(1);
    end

    // Advance the read pointer and its gray copy on each accepted read.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (take) begin
            rbin  <= rbin_inc;
            rgray <= rbin_inc ^ (rbin_inc >> 1);
        end
    end

    // Capture the head word into the output register on each accepted read.
    always_ff @(posedge rclk) begin
        if (!rst_n)    rd_data <= '0;
        else if (take) rd_data <= mem_rdata;
    end

    assign raddr = rbin[AW-1:0];

    AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!rst_n)
        (rd_en && !empty_n) |=> ($stable(rgray) && $stable(rd_data))); // R9
    AST_DATA_HELD_IDLE: assert property (@(posedge rclk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R2
    AST_EMPTY_IMPLIES_AEMPTY: assert property (@(posedge rclk) disable iff (!rst_n)
        !empty_n |-> !aempty_n); // R5
    AST_LEVEL_BOUNDED: assert property (@(posedge rclk) disable iff (!rst_n)
        rcount <= DEPTH_P); // R2

endmodule

// File: rtl/thresh_afifo.sv
`timescale 1ns/100ps
// Dual-clock FIFO with programmable almost-empty and almost-full margins.
// Assumes DEPTH is a power of two and both clocks run during reset.
module thresh_afifo
    import thresh_afifo_pkg::*;
#(
    parameter int DEPTH  = 512,
    parameter int WIDTH  = 36,
    parameter int X_DEF  = 8,
    parameter int Y_DEF  = 8,
    parameter int STAGES = 2,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic             wclk,
    input  logic             rclk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [PW-1:0]    cfg_data,
    output logic             full_n,
    output logic             afull_n,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty_n,
    output logic             aempty_n
);

    logic [AW-1:0]    waddr, raddr;
    logic [PW-1:0]    wgray, rgray, wgray_s, rgray_s, x_off;
    logic             mem_we;
    logic [WIDTH-1:0] mem_rdata;

    tafifo_wside #(.DEPTH(DEPTH), .X_DEF(X_DEF), .Y_DEF(Y_DEF)) u_wside (
        .wclk(wclk), .rst_n(rst_n), .wr_en(wr_en), .cfg_we(cfg_we),
        .cfg_sel(ofs_sel_e'(cfg_sel)), .cfg_data(cfg_data), .rgray_s(rgray_s),
        .waddr(waddr), .wgray(wgray), .mem_we(mem_we),
        .full_n(full_n), .afull_n(afull_n), .x_off(x_off)
    );

    tafifo_sync #(.W(PW), .STAGES(STAGES)) u_sync_r2w (
        .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
    );

    tafifo_sync #(.W(PW), .STAGES(STAGES)) u_sync_w2r (
        .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
    );

    tafifo_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
        .wclk(wclk), .we(mem_we), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(mem_rdata)
    );

    tafifo_rside #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rside (
        .rclk(rclk), .rst_n(rst_n), .rd_en(rd_en), .x_off(x_off),
        .wgray_s(wgray_s), .mem_rdata(mem_rdata), .raddr(raddr), .rgray(rgray),
        .rd_data(rd_data), .empty_n(empty_n), .aempty_n(aempty_n)
    );

endmodule

// File: tb/thresh_afifo_tb_top.sv
`timescale 1ns/100ps
// Directed bench: one task per scenario, each checking its own results.
module thresh_afifo_tb_top;

    localparam int DEPTH = 16;
    localparam int WIDTH = 36;
    localparam int XD    = 3;
    localparam int YD    = 3;
    localparam int PW    = $clog2(DEPTH) + 1;

    logic             wclk, rclk, rst_n;
    logic             wr_en, rd_en, cfg_we, cfg_sel;
    logic [WIDTH-1:0] wr_data, rd_data;
    logic [PW-1:0]    cfg_data;
    logic             full_n, afull_n, empty_n, aempty_n;

    int checks = 0;
    int errors = 0;

    thresh_afifo #(.DEPTH(DEPTH), .WIDTH(WIDTH), .X_DEF(XD), .Y_DEF(YD)) dut_i (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .full_n(full_n), .afull_n(afull_n), .rd_en(rd_en), .rd_data(rd_data),
        .empty_n(empty_n), .aempty_n(aempty_n)
    );

    // 200 MHz write clock; rising edges never coincide with read-clock edges
    initial begin
        wclk = 0;
        #1.3;
        forever begin wclk = 1; #2.5; wclk = 0; #2.5; end
    end

    initial begin
        rclk = 0;
        #3.5;
        forever begin rclk = 1; #3.5; rclk = 0; #3.5; end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(posedge wclk);
        repeat (3) @(posedge rclk);
        #0.1 rst_n = 1;
    endtask

    task automatic wr(input logic [WIDTH-1:0] d);
        wr_en = 1; wr_data = d;
        @(posedge wclk); #0.1;
        wr_en = 0;
    endtask

    task automatic rd();
        rd_en = 1;
        @(posedge rclk); #0.1;
        rd_en = 0;
    endtask

    task automatic cfg(input logic sel, input int val);
        cfg_we = 1; cfg_sel = sel; cfg_data = PW'(val);
        @(posedge wclk); #0.1;
        cfg_we = 0;
    endtask

    task automatic settle();
        repeat (4) @(posedge rclk);
        repeat (4) @(posedge wclk);
        #0.1;
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R1 full_n", full_n, 1);
        check("R1 afull_n", afull_n, 1);
        check("R1 empty_n", empty_n, 0);
        check("R1 aempty_n", aempty_n, 0);
        check("R1 rd_data", rd_data, 0);
    endtask

    task automatic t_order();
        do_reset();
        for (int i = 0; i < 6; i++) wr(36'h5_0000_0000 | 36'(i * 37 + 1));
        settle();
        for (int i = 0; i < 6; i++) begin
            rd();
            check("R2 order", rd_data, 36'h5_0000_0000 | 36'(i * 37 + 1));
        end
        repeat (3) @(posedge rclk); #0.1;
        check("R2 hold", rd_data, 36'h5_0000_0000 | 36'(5 * 37 + 1));
        check("R2 empty after drain", empty_n, 0);
    endtask

    task automatic t_almost_empty();
        do_reset();
        for (int i = 0; i < XD; i++) wr(36'(100 + i));
        settle();
        check("R5 level X", aempty_n, 0);
        check("R5 not empty", empty_n, 1);
        wr(36'(100 + XD));
        @(posedge rclk); #0.1;
        check("R5 first edge still low", aempty_n, 0);
        @(posedge rclk); #0.1;
        check("R5 second edge high", aempty_n, 1);
        rd();
        check("R6 immediate low", aempty_n, 0);
        check("R6 head word", rd_data, 100);
    endtask

    task automatic t_full();
        do_reset();
        for (int i = 0; i < DEPTH - 1; i++) wr(36'(200 + i));
        check("R3 not full at DEPTH-1", full_n, 1);
        wr(36'(200 + DEPTH - 1));
        check("R3 full at DEPTH", full_n, 0);
        wr(36'hBAD);
        check("R3 still full", full_n, 0);
        settle();
        rd();
        @(posedge wclk); #0.1;
        check("R4 first edge still full", full_n, 0);
        @(posedge wclk); #0.1;
        check("R4 second edge released", full_n, 1);
        check("R3 first word", rd_data, 200);
        for (int i = 1; i < DEPTH; i++) begin
            rd();
            if (rd_data !== 36'(200 + i)) check("R3 drained sequence", rd_data, 36'(200 + i));
        end
        checks++;
        check("R3 dropped write absent", empty_n, 0);
    endtask

    task automatic t_almost_full();
        do_reset();
        for (int i = 0; i < DEPTH - YD - 1; i++) wr(36'(i));
        check("R7 below threshold", afull_n, 1);
        wr(36'h77);
        check("R7 immediate low", afull_n, 0);
        settle();
        rd();
        @(posedge wclk); #0.1;
        check("R7 first edge still low", afull_n, 0);
        @(posedge wclk); #0.1;
        check("R7 second edge high", afull_n, 1);
    endtask

    task automatic t_offsets();
        do_reset();
        cfg(1'b0, 5);
        cfg(1'b1, 1);
        for (int i = 0; i < 5; i++) wr(36'(i));
        settle();
        check("R8 new X level 5", aempty_n, 0);
        wr(36'h6);
        settle();
        check("R8 new X level 6", aempty_n, 1);
        for (int i = 0; i < 8; i++) wr(36'(i));
        check("R8 new Y level 14", afull_n, 1);
        wr(36'hF);
        check("R8 new Y level 15", afull_n, 0);
        do_reset();
        for (int i = 0; i < XD + 1; i++) wr(36'(i));
        settle();
        check("R1 default X restored", aempty_n, 1);
    endtask

    task automatic t_empty_read();
        do_reset();
        rd();
        check("R9 data kept", rd_data, 0);
        check("R9 still empty", empty_n, 0);
        wr(36'h55);
        settle();
        rd();
        check("R9 next word", rd_data, 36'h55);
        check("R9 empty again", empty_n, 0);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; wr_en = 0; rd_en = 0; cfg_we = 0; cfg_sel = 0;
        cfg_data = '0; wr_data = '0;
        t_reset_state();
        t_order();
        t_almost_empty();
        t_full();
        t_almost_full();
        t_offsets();
        t_empty_read();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule